// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the host-facing output stage of a data converter. It holds one 16-bit result word and shifts it out to a host that supplies its own serial clock. The host selects the port with an active-low chip select and watches an active-low ready flag to learn that a word is waiting. The serial data line is presented as a data bit plus an output enable, which a pad wrapper turns into a three-state pin.

New result words arrive from the converter core as a single-cycle strobe with data. A word that arrives while the host is reading with chip select low is thrown away, so the transfer in progress is not corrupted. A word that arrives while an earlier word is still unread and chip select is high replaces it. In that case the ready flag first goes high for a fixed four-cycle pulse. The host may raise chip select part-way through a word. When chip select falls again, shifting resumes at the bit where it stopped.

The host serial clock is brought into the master clock domain through a two-flop synchroniser, and only its falling edges are used. The master clock must run at least four times faster than the serial clock.

Top module: `ser_readout_port`

## Requirements
- R1: After reset, rdy_no is high (no word waiting) and sdo_oe_o is low.
- R2: A word_stb_i pulse while no word is held loads word_i into the output register, and rdy_no is low from the next clock edge.
- R3: sdo_oe_o is high exactly when cs_ni is low and a word is waiting (rdy_no low). The moment it rises, sdo_o already carries bit 15 of the word, before any serial clock edge.
- R4: Each falling edge of sclk_i during an enabled transfer moves sdo_o to the next lower bit. After 15 falling edges, sdo_o carries bit 0.
- R5: On the 16th falling edge of a transfer, the word counts as read: rdy_no goes high and sdo_oe_o goes low.
- R6: When cs_ni rises mid-transfer, sdo_oe_o drops at once. When cs_ni falls again, sdo_o resumes at the same bit, and the word is not restarted.
- R7: A word_stb_i pulse while cs_ni is low and a word is waiting is discarded. rdy_no stays low and the word being sent is unchanged.
- R8: A word_stb_i pulse while an unread word is held and cs_ni is high drives rdy_no high for exactly four clock cycles. rdy_no then falls as the new word is loaded, and the new word is read from bit 15.
- R9: A word_stb_i pulse during that four-cycle high pulse is ignored. The word loaded at the end of the pulse is the one that started it.
- R10: Falling edges of sclk_i while cs_ni is high do not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Result word from the converter core |
| word_stb_i | input | 1 | One-cycle strobe: word_i holds a new result |
| cs_ni | input | 1 | Host chip select, active low |
| sclk_i | input | 1 | Host serial clock, idle high, asynchronous |
| rdy_no | output | 1 | Word waiting, active low |
| sdo_o | output | 1 | Serial data bit, forced low when disabled |
| sdo_oe_o | output | 1 | Serial data output enable |

## Verification
The bound checker watches several properties on every cycle:
- The data enable is never high while chip select or the ready flag is high.
- The bit position does not move while chip select is high, except when a new word is loaded.
- A strobe that arrives during a selected transfer leaves the ready flag low and the shift register unchanged.
- Completing a word always raises the ready flag.

Other behaviours only show up over a whole sequence, so the directed scenarios cover them:
- Exact bit order, including the MSB appearing the moment chip select falls.
- Resuming after an interruption at the correct bit.
- The length of the four-cycle replacement pulse.
- Which word is loaded after a strobe is ignored during that pulse.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef enum logic [1:0] {
    RS_EMPTY = 2'd0,
    RS_FULL  = 2'd1,
    RS_PULSE = 2'd2
  } rdy_state_e;
endpackage

// File: rtl/sro_edge_sync.sv
module sro_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/sro_ready_ctl.sv
module sro_ready_ctl
  import sro_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic cs_ni,
  input  logic done_i,
  output logic load_o,
  output logic load_sel_o,
  output logic capture_o,
  output logic valid_o
);
  localparam int PCW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PCW-1:0] PLAST = PCW'(PULSE_CYC - 1);

  rdy_state_e state_q, state_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic pulse_last;

  assign pulse_last = (state_q == RS_PULSE) && (pcnt_q == PLAST);
  assign valid_o    = (state_q == RS_FULL);
  assign load_o     = ((state_q == RS_EMPTY) && stb_i) || pulse_last;
  assign load_sel_o = (state_q == RS_PULSE);
  // replacement only when host is deselected; with cs low the strobe is dropped
  assign capture_o  = (state_q == RS_FULL) && stb_i && cs_ni && !done_i;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      RS_EMPTY: if (stb_i) state_d = RS_FULL;
      RS_FULL: begin
        if (done_i) begin
          state_d = RS_EMPTY;
        end else if (capture_o) begin
          state_d = RS_PULSE;
          pcnt_d  = '0;
        end
      end
      RS_PULSE: begin
        if (pulse_last) state_d = RS_FULL;
        else            pcnt_d  = pcnt_q + 1'b1;
      end
      default: state_d = RS_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_EMPTY;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end
endmodule

// File: rtl/sro_shift_path.sv
module sro_shift_path #(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  word_i,
  input  logic          capture_i,
  input  logic          load_i,
  input  logic          load_sel_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          done_o,
  output logic [$clog2(W)-1:0] cnt_o,
  output logic [W-1:0]  shreg_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CLAST = CW'(W - 1);

  logic [W-1:0]  hold_q, out_q;
  logic [CW-1:0] cnt_q, idx;

  assign done_o = shift_i && (cnt_q == CLAST);
  assign idx    = CLAST - cnt_q;
  assign bit_o  = out_q[idx];
  assign cnt_o  = cnt_q;
  assign shreg_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (capture_i) hold_q <= word_i;
      if (load_i)    out_q  <= load_sel_i ? hold_q : word_i;
      // position persists across chip-select gaps
      if (load_i || done_o) cnt_q <= '0;
      else if (shift_i)     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_readout_port.sv
module ser_readout_port #(
  parameter int W         = 16,
  parameter int SYNC_STG  = 2,
  parameter int PULSE_CYC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         word_stb_i,
  input  logic         cs_ni,
  input  logic         sclk_i,
  output logic         rdy_no,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  localparam int CW = $clog2(W);

  logic sclk_fall, load_w, load_sel_w, capture_w, valid_w;
  logic active_w, shift_w, done_w, bit_w;
  logic [CW-1:0] cnt_w;
  logic [W-1:0]  shreg_w;

  sro_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sclk_i),
    .fall_o (sclk_fall)
  );

  sro_ready_ctl #(.PULSE_CYC(PULSE_CYC)) u_rdy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (word_stb_i),
    .cs_ni     (cs_ni),
    .done_i    (done_w),
    .load_o    (load_w),
    .load_sel_o(load_sel_w),
    .capture_o (capture_w),
    .valid_o   (valid_w)
  );

  assign active_w = valid_w && !cs_ni;
  assign shift_w  = sclk_fall && active_w;

  sro_shift_path #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word_i),
    .capture_i (capture_w),
    .load_i    (load_w),
    .load_sel_i(load_sel_w),
    .shift_i   (shift_w),
    .bit_o     (bit_w),
    .done_o    (done_w),
    .cnt_o     (cnt_w),
    .shreg_o   (shreg_w)
  );

  assign rdy_no   = !valid_w;
  assign sdo_oe_o = active_w;
  assign sdo_o    = active_w && bit_w;
endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          rdy_no,
  input logic          sdo_oe_o,
  input logic          word_stb_i,
  input logic          load,
  input logic          done,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  shreg
);
  p_hiz_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_oe_o);

  p_hiz_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_no |-> !sdo_oe_o);

  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !load) |=> $stable(cnt));

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && !rdy_no && !cs_ni && !done) |=> (!rdy_no && $stable(shreg)));

  p_done_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rdy_no);
endmodule

bind ser_readout_port sro_checker #(.W(W), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rdy_no    (rdy_no),
  .sdo_oe_o  (sdo_oe_o),
  .word_stb_i(word_stb_i),
  .load      (load_w),
  .done      (done_w),
  .cnt       (cnt_w),
  .shreg     (shreg_w)
);

// File: tb/ser_readout_port_test.sv
`timescale 1ns/1ps
module ser_readout_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word = '0;
  logic        stb = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        rdy_n, sdo, sdo_oe;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  ser_readout_port uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_stb_i(stb),
    .cs_ni(cs_n), .sclk_i(sclk), .rdy_no(rdy_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] w);
    @(negedge clk); word = w; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic sclk_fall();
    @(negedge clk); sclk = 1'b0;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_low_msb(input logic [15:0] w, input string req);
    @(negedge clk); cs_n = 1'b0; #1;
    chk(sdo_oe == 1'b1, req, sdo_oe, 1);
    chk(sdo == w[15], req, sdo, w[15]);
  endtask

  // issue falls, checking bit index after each
  task automatic shift_bits(input logic [15:0] w, input int from, input int to, input string req);
    for (int i = from; i <= to; i++) begin
      sclk_fall();
      chk(sdo == w[15-i], req, sdo, w[15-i]);
    end
  endtask

  task automatic finish_word(input string req);
    sclk_fall();
    chk(rdy_n == 1'b1, req, rdy_n, 1);
    chk(sdo_oe == 1'b0, req, sdo_oe, 0);
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rdy_n == 1'b1, "R1", rdy_n, 1);
    chk(sdo_oe == 1'b0, "R1", sdo_oe, 0);
  endtask

  task automatic t_basic_read();
    logic [15:0] w = 16'hA53C;
    strobe(w);
    chk(rdy_n == 1'b0, "R2", rdy_n, 0);
    chk(sdo_oe == 1'b0, "R3", sdo_oe, 0);
    cs_low_msb(w, "R3");
    shift_bits(w, 1, 15, "R4");
    finish_word("R5");
  endtask

  task automatic t_interrupt();
    logic [15:0] w = 16'h8E61;
    strobe(w);
    cs_low_msb(w, "R6");
    shift_bits(w, 1, 5, "R6");
    @(negedge clk); cs_n = 1'b1; #1;
    chk(sdo_oe == 1'b0, "R6", sdo_oe, 0);
    repeat (3) sclk_fall();  // R10: must not advance
    chk(rdy_n == 1'b0, "R10", rdy_n, 0);
    @(negedge clk); cs_n = 1'b0; #1;
    chk(sdo_oe == 1'b1, "R6", sdo_oe, 1);
    chk(sdo == w[10], "R10", sdo, w[10]);
    shift_bits(w, 6, 15, "R6");
    finish_word("R5");
  endtask

  task automatic t_drop();
    logic [15:0] w = 16'h3C5A;
    strobe(w);
    cs_low_msb(w, "R7");
    shift_bits(w, 1, 3, "R7");
    strobe(16'hFFFF);
    chk(rdy_n == 1'b0, "R7", rdy_n, 0);
    chk(sdo == w[12], "R7", sdo, w[12]);
    shift_bits(w, 4, 15, "R7");
    finish_word("R7");
  endtask

  task automatic t_replace();
    logic [15:0] w_old = 16'h1234;
    logic [15:0] w_new = 16'hC0DE;
    strobe(w_old);
    strobe(w_new);          // strobe sampled one edge ago, pulse running
    chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    @(negedge clk); word = 16'h0F0F; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    chk(rdy_n == 1'b1, "R9", rdy_n, 1);
    @(negedge clk);
    chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    @(negedge clk);
    chk(rdy_n == 1'b0, "R8", rdy_n, 0);
    cs_low_msb(w_new, "R9");
    shift_bits(w_new, 1, 15, "R9");
    finish_word("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_read();
    t_interrupt();
    t_drop();
    t_replace();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule